// File: doc/BRIEF.md
# Shared Interrupt and Mailbox Controller

This block gathers a few level-sensitive device interrupt lines and a set of software mailbox bits into one pending word pair. It then gives each CPU of a small multiprocessor its own enable mask and its own interrupt output. Software reaches all state over a simple 32-bit word bus. Each access takes one cycle, and read data returns on the edge that accepts the read.

The pending (raw) state is global and has three views: a plain register, a set-by-ones alias and a clear-by-ones alias. Each CPU has its own region holding four views: a masked source view (raw AND that CPU's enable), the enable register, and set-by-ones and clear-by-ones aliases of the enable. Any CPU can interrupt another by setting one of the target's two mailbox bits through the raw set alias. The target acknowledges through the raw clear alias.

The group size follows the advertised bit count. With the default of 64 bits, every group is two words and every per-CPU region is 32 bytes.

Top module: `irq_mbox_ctrl`

## Requirements
- R1: Offset 0x00 reads the advertised bit count (64 by default). Writes to it are ignored. Offset 0x04 reads zero.
- R2: After reset, every raw and enable bit is 0, every irq_o bit is low and rdata_o is 0.
- R3: The global raw groups sit at 0x08 (plain), 0x10 (set alias) and 0x18 (clear alias). CPU n's region starts at 0x20 + n*0x20 and holds the source view at +0x00, the enable at +0x08, the enable set alias at +0x10 and the enable clear alias at +0x18. Each group is two words: the device word at +0 and the mailbox word at +4.
- R4: Device line i is raw bit i of the device word. The bit is set at any edge where the line is high and no raw write targets the device word in that cycle. A clear of a line that is still high reads 0 for one cycle, then reads 1 again.
- R5: Mailbox bit m of CPU c is bit c*2+m of the mailbox word. Only software writes change it. irq_o[c] falls when the bit is acknowledged.
- R6: A write to a set alias sets exactly the bits written as 1. A write to a clear alias clears exactly those bits. Bits written as 0 keep their value. This applies to both raw and enable state.
- R7: A write to the plain raw or enable register replaces every implemented bit of the addressed word.
- R8: Reads of a set or clear alias return the same value as the plain register of the same group.
- R9: The source view of CPU n reads raw AND CPU n's enable. It is read-only.
- R10: irq_o[n] is high exactly while CPU n's source view is non-zero. It follows state changes on the same edge, with no extra register stage.
- R11: Unmapped or misaligned offsets, and CPU indices past the last CPU, read as 0 and ignore writes. Unimplemented bits read as 0 and cannot be set.
- R12: rdata_o loads the addressed value at each edge where req_i is high and we_i is low. The value is the state before that edge. At all other edges rdata_o holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_irq_i | input | NUM_LINES | Level-sensitive device interrupt lines |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the accessed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NUM_CPUS | Interrupt request, one per CPU |

## Verification
A write changes raw or enable state at the edge that accepts it. irq_o reflects the new state right after that edge, because it has no register of its own. A read returns the value from before its own edge, and rdata_o shows that value right after the edge. A line that is held high through a clear therefore reads 0 on the read that directly follows the clear, and reads 1 on the read after that. The bench drives inputs and samples outputs on falling edges, one half period from these edges. The reference model updates on rising edges in the same order as the hardware, so the expected rdata_o and irq_o are due on exactly the falling edge where they are compared.

// File: rtl/irq_mbox_pkg.sv
package irq_mbox_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_ID,
    K_RAW,
    K_RAW_SET,
    K_RAW_CLR,
    K_SRC,
    K_EN,
    K_EN_SET,
    K_EN_CLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [7:0]  cpu;
    logic [7:0]  word;
  } reg_sel_t;

  function automatic logic is_raw_op(reg_kind_e k);
    return (k == K_RAW) || (k == K_RAW_SET) || (k == K_RAW_CLR);
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_mbox_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_BITS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);

  localparam int STRIDE_B = 8 * (1 + (NUM_BITS - 1) / 64);
  localparam int SPAN_B   = 4 * STRIDE_B;
  localparam int CPU_B    = 8 + 3 * STRIDE_B;
  localparam int END_B    = CPU_B + NUM_CPUS * SPAN_B;

  localparam logic [ADDR_W-1:0] A_GRP    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_STRIDE = ADDR_W'(STRIDE_B);
  localparam logic [ADDR_W-1:0] A_SPAN   = ADDR_W'(SPAN_B);
  localparam logic [ADDR_W-1:0] A_CPU    = ADDR_W'(CPU_B);
  localparam logic [ADDR_W-1:0] A_END    = ADDR_W'(END_B);

  logic [ADDR_W-1:0] rel, sub, grp;

  always_comb begin
    sel_o = '{kind: K_NONE, cpu: 8'd0, word: 8'd0};
    rel   = '0;
    sub   = '0;
    grp   = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == '0) begin
        sel_o.kind = K_ID;
      end else if (addr_i >= A_GRP && addr_i < A_CPU) begin
        rel        = addr_i - A_GRP;
        grp        = rel / A_STRIDE;
        sel_o.word = 8'((rel % A_STRIDE) >> 2);
        case (grp)
          ADDR_W'(0): sel_o.kind = K_RAW;
          ADDR_W'(1): sel_o.kind = K_RAW_SET;
          default:    sel_o.kind = K_RAW_CLR;
        endcase
      end else if (addr_i >= A_CPU && addr_i < A_END) begin
        rel        = addr_i - A_CPU;
        sel_o.cpu  = 8'(rel / A_SPAN);
        sub        = rel % A_SPAN;
        grp        = sub / A_STRIDE;
        sel_o.word = 8'((sub % A_STRIDE) >> 2);
        case (grp)
          ADDR_W'(0): sel_o.kind = K_SRC;
          ADDR_W'(1): sel_o.kind = K_EN;
          ADDR_W'(2): sel_o.kind = K_EN_SET;
          default:    sel_o.kind = K_EN_CLR;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_raw_state.sv
module irq_raw_state
  import irq_mbox_pkg::*;
#(
  parameter int                  STATE_W   = 64,
  parameter int                  NUM_LINES = 4,
  parameter int                  MBOX_W    = 8,
  parameter logic [STATE_W-1:0]  IMPL      = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 wr_i,
  input  reg_kind_e            op_i,
  input  logic [STATE_W-1:0]   wmask_i,
  input  logic [STATE_W-1:0]   wsel_i,
  output logic [STATE_W-1:0]   raw_o
);

  logic [STATE_W-1:0] raw_q, raw_d;
  logic               line_blk;

  always_comb begin
    raw_d    = raw_q;
    line_blk = 1'b0;
    if (wr_i) begin
      case (op_i)
        K_RAW:     begin raw_d = (raw_q & ~wsel_i) | wmask_i; line_blk = wsel_i[0]; end
        K_RAW_SET: begin raw_d = raw_q | wmask_i;             line_blk = wsel_i[0]; end
        K_RAW_CLR: begin raw_d = raw_q & ~wmask_i;            line_blk = wsel_i[0]; end
        default:   ;
      endcase
    end
    // a write to the device word owns that edge; a held line re-sets next edge
    if (!line_blk) raw_d[NUM_LINES-1:0] = raw_d[NUM_LINES-1:0] | line_i;
    raw_d = raw_d & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  a_r4_line_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && is_raw_op(op_i) && wsel_i[0])
    |=> ((raw_q[NUM_LINES-1:0] & $past(line_i)) == $past(line_i)));

  a_r5_mbox_sw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && is_raw_op(op_i)) |=> $stable(raw_q[32 +: MBOX_W]));

  a_r6_raw_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == K_RAW_CLR) |=> ((raw_q & $past(wmask_i)) == '0));

endmodule

// File: rtl/irq_cpu_enable.sv
module irq_cpu_enable
  import irq_mbox_pkg::*;
#(
  parameter int                 STATE_W = 64,
  parameter logic [STATE_W-1:0] IMPL    = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  reg_kind_e          op_i,
  input  logic [STATE_W-1:0] wmask_i,
  input  logic [STATE_W-1:0] wsel_i,
  output logic [STATE_W-1:0] en_o
);

  logic [STATE_W-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) begin
      case (op_i)
        K_EN:     en_d = (en_q & ~wsel_i) | wmask_i;
        K_EN_SET: en_d = en_q | wmask_i;
        K_EN_CLR: en_d = en_q & ~wmask_i;
        default:  ;
      endcase
    end
    en_d = en_d & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  a_r6_en_set_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == K_EN_SET) |=> (((en_q ^ $past(en_q)) & ~$past(wmask_i)) == '0));

  a_r6_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == K_EN_CLR) |=> ((en_q & $past(wmask_i)) == '0));

endmodule

// File: rtl/irq_mbox_ctrl.sv
module irq_mbox_ctrl
  import irq_mbox_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_LINES = 4,
  parameter int NUM_BITS  = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] dev_irq_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_CPUS-1:0]  irq_o
);

  localparam int STRIDE_B = 8 * (1 + (NUM_BITS - 1) / 64);
  localparam int STATE_W  = 8 * STRIDE_B;
  localparam int MBOX_W   = 2 * NUM_CPUS;
  localparam logic [STATE_W-1:0] LINE_M = (STATE_W'(1) << NUM_LINES) - STATE_W'(1);
  localparam logic [STATE_W-1:0] MBOX_M = ((STATE_W'(1) << MBOX_W) - STATE_W'(1)) << 32;
  localparam logic [STATE_W-1:0] IMPL   = LINE_M | MBOX_M;

  reg_sel_t           sel;
  logic [STATE_W-1:0] wmask, wsel, raw;
  logic [STATE_W-1:0] en  [NUM_CPUS];
  logic [STATE_W-1:0] en_pick;
  logic [31:0]        rd_val, rdata_q;
  logic               wr;

  irq_addr_decode #(
    .NUM_CPUS(NUM_CPUS), .NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign wr    = req_i && we_i;
  assign wmask = STATE_W'(wdata_i) << {sel.word, 5'b0};
  assign wsel  = STATE_W'(32'hFFFF_FFFF) << {sel.word, 5'b0};

  irq_raw_state #(
    .STATE_W(STATE_W), .NUM_LINES(NUM_LINES), .MBOX_W(MBOX_W), .IMPL(IMPL)
  ) u_raw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (dev_irq_i),
    .wr_i   (wr),
    .op_i   (sel.kind),
    .wmask_i(wmask),
    .wsel_i (wsel),
    .raw_o  (raw)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_cpu_enable #(
      .STATE_W(STATE_W), .IMPL(IMPL)
    ) u_en (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr && (sel.cpu == 8'(c))),
      .op_i   (sel.kind),
      .wmask_i(wmask),
      .wsel_i (wsel),
      .en_o   (en[c])
    );
    assign irq_o[c] = |(raw & en[c]);
  end

  always_comb begin
    en_pick = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (sel.cpu == 8'(c)) en_pick = en[c];
  end

  always_comb begin
    case (sel.kind)
      K_ID:                       rd_val = 32'(NUM_BITS);
      K_RAW, K_RAW_SET, K_RAW_CLR: rd_val = 32'(raw >> {sel.word, 5'b0});
      K_SRC:                      rd_val = 32'((raw & en_pick) >> {sel.word, 5'b0});
      K_EN, K_EN_SET, K_EN_CLR:   rd_val = 32'(en_pick >> {sel.word, 5'b0});
      default:                    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (req_i && !we_i)   rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  a_r1_id_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == '0) |=> (rdata_o == 32'(NUM_BITS)));

  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel.kind == K_NONE) |=> (rdata_o == '0));

  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  a_r10_irq_fall_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(irq_o) & ~irq_o)) |-> $past(req_i && we_i));

endmodule

// File: tb/irq_mbox_ctrl_test.sv
`timescale 1ns/1ps
module irq_mbox_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dev = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_mbox_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .dev_irq_i(dev), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  localparam logic [63:0] IMPL = 64'h0000_00FF_0000_000F;
  logic [63:0] m_raw;
  logic [63:0] m_en [4];
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(logic [11:0] a);
    int ai, c, g, w;
    logic [63:0] v;
    ai = int'(a);
    if (ai[1:0] != 2'b00) return 0;
    if (ai == 0) return 64;
    w = (ai % 8) / 4;
    if (ai >= 8 && ai < 32) v = m_raw;
    else if (ai >= 32 && ai < 160) begin
      c = (ai - 32) / 32;
      g = ((ai - 32) % 32) / 8;
      v = (g == 0) ? (m_raw & m_en[c]) : m_en[c];
    end else return 0;
    return (w == 0) ? v[31:0] : v[63:32];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = '0;
      for (int c = 0; c < 4; c++) m_en[c] = '0;
      m_rd = '0;
    end else begin
      int ai, c, g, w;
      logic [63:0] mv, ms;
      bit blk;
      blk = 1'b0;
      if (req && !we) m_rd = m_read(addr);
      if (req && we) begin
        ai = int'(addr);
        w  = (ai % 8) / 4;
        mv = (w == 0) ? {32'd0, wdata} : {wdata, 32'd0};
        ms = (w == 0) ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_0000_0000;
        if (ai[1:0] == 2'b00 && ai >= 8 && ai < 32) begin
          g = (ai - 8) / 8;
          blk = (w == 0);
          if (g == 0)      m_raw = (m_raw & ~ms) | mv;
          else if (g == 1) m_raw = m_raw | mv;
          else             m_raw = m_raw & ~mv;
        end else if (ai[1:0] == 2'b00 && ai >= 32 && ai < 160) begin
          c = (ai - 32) / 32;
          g = ((ai - 32) % 32) / 8;
          if (g == 1)      m_en[c] = (m_en[c] & ~ms) | mv;
          else if (g == 2) m_en[c] = m_en[c] | mv;
          else if (g == 3) m_en[c] = m_en[c] & ~mv;
          m_en[c] = m_en[c] & IMPL;
        end
      end
      if (!blk) m_raw[3:0] = m_raw[3:0] | dev;
      m_raw = m_raw & IMPL;
    end
  end

  // per-clock comparison, half a period after the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] ei;
      for (int c = 0; c < 4; c++) ei[c] = |(m_raw & m_en[c]);
      checks++;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL R12 rdata_o: got %h exp %h", rdata, m_rd);
      end
      checks++;
      if (irq !== ei) begin
        errors++;
        $display("FAIL R10 irq_o: got %b exp %b", irq, ei);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 irq_o", 32'(irq), 0);
    chk("R2 rdata_o", rdata, 0);
    rd(12'h008, 0, "R2 raw");
    rd(12'h028, 0, "R2 en");
    // R1 id
    rd(12'h000, 64, "R1 id");
    rd(12'h004, 0, "R1 off4");
    // R4 line latch
    dev = 4'b0101;
    @(negedge clk);
    dev = 4'b0000;
    rd(12'h008, 32'h5, "R4 latch");
    wr(12'h018, 32'h1);
    rd(12'h008, 32'h4, "R6 raw clr");
    dev[2] = 1'b1;
    wr(12'h018, 32'h4);
    rd(12'h008, 32'h0, "R4 clr while high");
    rd(12'h008, 32'h4, "R4 re-set");
    dev = 4'b0000;
    wr(12'h018, 32'h4);
    rd(12'h008, 32'h0, "R6 raw clr low");
    // R5 mailbox: CPU2 box1 = mailbox word bit 5
    wr(12'h014, 32'h20);
    rd(12'h00C, 32'h20, "R5 mbox raise");
    rd(12'h01C, 32'h20, "R8 clr alias read");
    rd(12'h014, 32'h20, "R8 set alias read");
    chk("R10 masked", 32'(irq), 0);
    wr(12'h074, 32'h20);
    chk("R10 cpu2 irq", 32'(irq), 32'h4);
    rd(12'h064, 32'h20, "R9 src cpu2");
    rd(12'h044, 32'h0, "R9 src cpu1");
    wr(12'h01C, 32'h20);
    chk("R5 ack", 32'(irq), 0);
    rd(12'h06C, 32'h20, "R8 en base");
    rd(12'h07C, 32'h20, "R8 en clr alias");
    // R7 replace, R6 enable aliases
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h028, 32'hF, "R7 R11 en replace");
    wr(12'h038, 32'h2);
    rd(12'h028, 32'hD, "R6 en clr");
    wr(12'h028, 32'h1);
    rd(12'h028, 32'h1, "R7 en replace");
    wr(12'h008, 32'hA);
    rd(12'h008, 32'hA, "R7 raw replace");
    chk("R10 no overlap", 32'(irq), 0);
    wr(12'h030, 32'h8);
    chk("R10 cpu0 irq", 32'(irq), 32'h1);
    rd(12'h020, 32'h8, "R9 src cpu0");
    // R11 unmapped, misaligned, read-only
    wr(12'h0A0, 32'hFFFF_FFFF);
    wr(12'h00A, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFF0);
    rd(12'h008, 32'hA, "R11 raw intact");
    rd(12'h028, 32'h9, "R11 en intact");
    rd(12'h0A0, 32'h0, "R11 past last cpu");
    rd(12'h009, 32'h0, "R11 misaligned");
    rd(12'h000, 64, "R11 id intact");
    // R3 layout, CPU3 region
    wr(12'h08C, 32'hC0);
    wr(12'h014, 32'h40);
    chk("R3 cpu3 irq", 32'(irq), 32'h9);
    rd(12'h084, 32'h40, "R3 cpu3 src");
    @(negedge clk);
    chk("R12 hold", rdata, 32'h40);
    // R2 reset again
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 irq after reset", 32'(irq), 0);
    rd(12'h084, 32'h0, "R2 src after reset");
    rd(12'h00C, 32'h0, "R2 raw after reset");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule